// File: doc/BRIEF.md
# Two-Level Maskable Interrupt Controller

This block gathers interrupt requests for a small 8-bit processor core. Three core sources have their flags and enables in one control byte: an external pin edge, a port change and a timer overflow. That byte also holds a master enable and a peripheral-group enable. A parameterised set of peripheral sources keeps its flags and its enables in two further bytes. Each peripheral request has to pass its own enable, then the group enable, and then the master enable.

Each flag is set by its hardware event strobe. Software can also set or clear a flag through a small byte-wide register port. When the master enable is set and at least one unmasked flag is pending, the block raises a registered interrupt request to the core. A wake-up line follows the unmasked request directly and does not depend on the master enable, so it can rouse a sleeping core.

When the core vectors, it pulses an acknowledge. On that pulse the block clears the master enable, and it always presents the fixed vector address. A return strobe sets the master enable again. Flags are left for software to clear. Any flag still pending after the return raises the request again.

Top module: `irq_hub`

## Requirements
- R1: After reset every flag, every enable and the master enable are 0, and `irq` and `wake` are low.
- R2: A high `core_evt[i]` or `per_evt[j]` sets the matching flag at the next clock edge, whatever the state of any enable.
- R3: Register selects are 0 for control, 1 for peripheral flags and 2 for peripheral enables. The control byte is laid out as bit7 master enable, bit6 group enable, bits5:3 core enables and bits2:0 core flags. Core index 0 is port change, 1 is pin edge and 2 is timer overflow. Writing a 1 to a flag sets it and writing a 0 clears it. If a hardware event arrives in the same cycle as a software clear, the flag ends up set.
- R4: `irq` goes high one cycle after the master enable is set while a core flag and its enable are both set. `irq` is never high unless the master enable was set in the previous cycle.
- R5: A peripheral flag with its enable set contributes to `irq` and `wake` only while the group enable is set.
- R6: In the cycle after `vec_ack` is high, the master enable reads 0 and `irq` is low.
- R7: A `ret_strobe` without `vec_ack` sets the master enable at the next edge.
- R8: `vec_ack` and `ret_strobe` never clear a flag. A flag left set causes `irq` to rise again once the master enable has been restored.
- R9: `wake` is high exactly when an unmasked request is pending, whether or not the master enable is set.
- R10: `vec_addr` always carries the vector address 0x0004.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_evt | input | 3 | Core source event strobes |
| per_evt | input | NUM_PERIPH | Peripheral source event strobes |
| reg_sel | input | 2 | Register select |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for the selected register |
| vec_ack | input | 1 | Core vectoring acknowledge |
| ret_strobe | input | 1 | Return-from-interrupt strobe |
| irq | output | 1 | Registered interrupt request to the core |
| wake | output | 1 | Unmasked request, not gated by the master enable |
| vec_addr | output | PC_W | Fixed interrupt vector address |

## Verification
The hardest situations to reach are the ones where two causes meet in one clock. One is a hardware event that lands in the same cycle as a software write clearing its flag. The other is a flag that is still set when the return strobe restores the master enable. The bench produces both directly by driving the event strobe together with the control write, and by pulsing the acknowledge and then the return without clearing the flag. An exhaustive sweep covers all master-enable, group-enable, core-enable and core-flag combinations, each crossed with four peripheral flag and enable patterns.

// File: rtl/irq_hub.sv
module irq_hub #(
  parameter int NUM_PERIPH = 8,
  parameter int PC_W       = 13,
  parameter int VECTOR     = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [2:0]            core_evt,
  input  logic [NUM_PERIPH-1:0] per_evt,
  input  logic [1:0]            reg_sel,
  input  logic                  reg_we,
  input  logic [7:0]            reg_wdata,
  output logic [7:0]            reg_rdata,
  input  logic                  vec_ack,
  input  logic                  ret_strobe,
  output logic                  irq,
  output logic                  wake,
  output logic [PC_W-1:0]       vec_addr
);

  logic                  gie_q, grp_en_q, irq_q;
  logic [2:0]            cen_q, cflag_q;
  logic [NUM_PERIPH-1:0] pflag_q, pen_q;

  logic wr_ctrl, wr_pf, wr_pe, core_hit, per_hit, pending;

  assign wr_ctrl  = reg_we && (reg_sel == 2'd0);
  assign wr_pf    = reg_we && (reg_sel == 2'd1);
  assign wr_pe    = reg_we && (reg_sel == 2'd2);
  assign core_hit = |(cflag_q & cen_q);
  assign per_hit  = grp_en_q && |(pflag_q & pen_q);
  assign pending  = core_hit || per_hit;

  assign wake     = pending;
  assign irq      = irq_q;
  assign vec_addr = PC_W'(VECTOR);

  always_comb begin
    case (reg_sel)
      2'd0:    reg_rdata = {gie_q, grp_en_q, cen_q, cflag_q};
      2'd1:    reg_rdata = 8'(pflag_q);
      2'd2:    reg_rdata = 8'(pen_q);
      default: reg_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gie_q    <= 1'b0;
      grp_en_q <= 1'b0;
      cen_q    <= '0;
      cflag_q  <= '0;
      pflag_q  <= '0;
      pen_q    <= '0;
      irq_q    <= 1'b0;
    end else begin
      cflag_q <= (wr_ctrl ? reg_wdata[2:0] : cflag_q) | core_evt;
      pflag_q <= (wr_pf ? reg_wdata[NUM_PERIPH-1:0] : pflag_q) | per_evt;
      if (wr_ctrl) begin
        cen_q    <= reg_wdata[5:3];
        grp_en_q <= reg_wdata[6];
      end
      if (wr_pe) pen_q <= reg_wdata[NUM_PERIPH-1:0];
      if (vec_ack)         gie_q <= 1'b0;
      else if (ret_strobe) gie_q <= 1'b1;
      else if (wr_ctrl)    gie_q <= reg_wdata[7];
      irq_q <= gie_q && pending && !vec_ack;
    end
  end

  p_core_evt_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (core_evt != 3'b0) |=> ((cflag_q & $past(core_evt)) == $past(core_evt)));

  p_per_evt_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (per_evt != '0) |=> ((pflag_q & $past(per_evt)) == $past(per_evt)));

  p_irq_needs_gie_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(gie_q));

  p_group_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !$past(core_hit)) |-> $past(grp_en_q));

  p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    vec_ack |=> (!gie_q && !irq));

  p_ret_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_strobe && !vec_ack) |=> gie_q);

  p_flags_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((vec_ack || ret_strobe) && !reg_we) |=>
      (((cflag_q & $past(cflag_q)) == $past(cflag_q)) &&
       ((pflag_q & $past(pflag_q)) == $past(pflag_q))));

endmodule

// File: tb/sim_irq_hub.sv
module sim_irq_hub;
  logic       clk = 0, rst_n = 0;
  logic [2:0] core_evt = 0;
  logic [7:0] per_evt = 0;
  logic [1:0] reg_sel = 0;
  logic       reg_we = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic       vec_ack = 0, ret_strobe = 0, irq, wake;
  logic [12:0] vec_addr;
  int total = 0, failed = 0;
  bit done = 0;

  irq_hub u0 (.clk, .rst_n, .core_evt, .per_evt, .reg_sel, .reg_we, .reg_wdata,
              .reg_rdata, .vec_ack, .ret_strobe, .irq, .wake, .vec_addr);

  always #4 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      failed++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk); reg_sel = s; reg_wdata = d; reg_we = 1;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [7:0] d);
    reg_sel = s; #1; d = reg_rdata;
  endtask

  task automatic pulse_ack;
    @(negedge clk); vec_ack = 1; @(negedge clk); vec_ack = 0;
  endtask

  task automatic pulse_ret;
    @(negedge clk); ret_strobe = 1; @(negedge clk); ret_strobe = 0;
  endtask

  initial begin
    #1500000;
    if (!done) begin
      failed++; total++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    logic [7:0] pfs [4] = '{8'h00, 8'h01, 8'h0F, 8'h80};
    logic [7:0] pns [4] = '{8'h00, 8'h01, 8'hF0, 8'hFF};
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(0, r); chk("R1 ctrl", r, 0);
    rd(1, r); chk("R1 pflag", r, 0);
    rd(2, r); chk("R1 pen", r, 0);
    chk("R1 irq", irq, 0);
    chk("R1 wake", wake, 0);
    // R10
    chk("R10 vector", vec_addr, 4);

    // R2 events set flags with all enables clear
    @(negedge clk); core_evt = 3'b101; per_evt = 8'h42;
    @(negedge clk); core_evt = 0; per_evt = 0;
    rd(0, r); chk("R2 core flags", r, 8'h05);
    rd(1, r); chk("R2 per flags", r, 8'h42);
    chk("R2 wake masked", wake, 0);
    @(negedge clk); chk("R2 irq masked", irq, 0);

    // R3 event wins over software clear
    @(negedge clk); reg_sel = 0; reg_wdata = 8'h00; reg_we = 1; core_evt = 3'b010;
    @(negedge clk); reg_we = 0; core_evt = 0;
    rd(0, r); chk("R3 event wins", r, 8'h02);
    wr(1, 8'h00); rd(1, r); chk("R3 per clear", r, 0);
    wr(0, 8'h00); rd(0, r); chk("R3 ctrl clear", r, 0);

    // Exhaustive sweep: R3 readback, R9 wake, R4/R5 irq
    for (int g = 0; g < 2; g++)
      for (int p = 0; p < 2; p++)
        for (int ce = 0; ce < 8; ce++)
          for (int cf = 0; cf < 8; cf++)
            for (int k = 0; k < 4; k++) begin
              logic [7:0] cv;
              logic pend;
              cv = {g[0], p[0], ce[2:0], cf[2:0]};
              pend = ((ce & cf) != 0) || (p[0] && ((pfs[k] & pns[k]) != 0));
              wr(1, pfs[k]); wr(2, pns[k]); wr(0, cv);
              rd(0, r); chk("R3 sweep readback", r, cv);
              chk("R9 wake sweep", wake, pend);
              @(negedge clk);
              chk(((ce & cf) != 0) ? "R4 irq sweep" : "R5 irq sweep", irq, g[0] && pend);
            end

    // R6 / R8 / R7 vectoring cycle
    wr(1, 0); wr(2, 0);
    wr(0, 8'b1010_0100);
    @(negedge clk); chk("R4 irq raised", irq, 1);
    pulse_ack;
    rd(0, r); chk("R6 gie cleared", r[7], 0);
    chk("R6 irq low", irq, 0);
    chk("R8 flag kept", r[2], 1);
    chk("R9 wake gie clear", wake, 1);
    chk("R10 vector at ack", vec_addr, 4);
    @(negedge clk); chk("R6 irq stays low", irq, 0);
    pulse_ret;
    rd(0, r); chk("R7 gie set", r[7], 1);
    @(negedge clk); chk("R8 retaken", irq, 1);
    pulse_ack;
    wr(0, 8'b0010_0000);
    pulse_ret;
    rd(0, r); chk("R7 gie after clear", r, 8'hA0);
    @(negedge clk); chk("R8 no retake", irq, 0);

    // R5 peripheral path through group enable
    wr(2, 8'h10);
    @(negedge clk); per_evt = 8'h10; @(negedge clk); per_evt = 0;
    chk("R5 group off wake", wake, 0);
    @(negedge clk); chk("R5 group off irq", irq, 0);
    wr(0, 8'hC0);
    chk("R5 group on wake", wake, 1);
    @(negedge clk); chk("R5 group on irq", irq, 1);
    pulse_ack;
    rd(1, r); chk("R8 per flag kept", r, 8'h10);

    done = 1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule